// File: doc/BRIEF.md
# UART Register and FIFO Controller

This block is the software-facing half of a simple serial port. A 32-bit word bus with one-cycle reads and writes reaches seven registers through it. Two of them are the data ports of an eight-deep byte queue in each direction. The others hold the transmit settings, the receive settings, the interrupt mask, the pending flags and a 16-bit baud divisor. The bit-timing engines sit outside the block. The transmit serializer takes bytes from a valid/ready stream. The receive deserializer hands each byte over with a one-cycle strobe.

Transmit bytes leave as a valid/ready stream. `tx_valid` is high while transmission is enabled and the transmit queue holds a byte, and `tx_data` then shows the oldest byte. A byte leaves the queue on any clock edge where both `tx_valid` and `tx_ready` are high. While `tx_ready` is low, the byte on offer and its valid stay unchanged. The receive side has no back-pressure. A strobe that arrives while the queue is full, or while reception is off, is lost. The queue state is visible in bit 31 of each data register. Two level thresholds raise the pending flags, and the interrupt mask selects which of them drive `irq`.

Top module: `uart_csr_fifo`

## Requirements
- R1: After reset every register reads zero, except the receive data register at 0x04. It reads 0x8000_0000 because the receive queue is empty.
- R2: A write to 0x00 pushes wdata[7:0] onto the transmit queue, which holds eight bytes. A read of 0x00 returns the queue-full flag in bit 31 and zero in bits 30:0. A write while the queue is full is dropped.
- R3: `tx_valid` is high exactly when transmit control bit 0 is set and the transmit queue is not empty. `tx_data` is the oldest byte. Bytes leave in the order they were written, one on each edge with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R4: A read of 0x04 returns the oldest received byte in bits 7:0 and the empty flag in bit 31. Bits 30:8 read zero, and bits 7:0 read zero while the queue is empty. A read with `bus_rd` high removes that byte, but only if the queue is not empty.
- R5: When `rx_strobe` is high, `rx_byte` is stored only if receive control bit 0 is set and the receive queue is not full. Otherwise the byte is discarded.
- R6: Transmit control at 0x08 holds the enable in bit 0, the two-stop-bit select in bit 1 and a 3-bit watermark in bits 18:16. Receive control at 0x0C holds the enable in bit 0 and a 3-bit watermark in bits 18:16. All other bits read zero. `tx_en`, `tx_two_stop` and `rx_en` follow the stored bits.
- R7: The divisor at 0x18 keeps bits 15:0, which appear on `baud_div`, and reads zero in bits 31:16.
- R8: The pending register at 0x14 shows two flags. Bit 0 is high while the transmit count is below the transmit watermark. Bit 1 is high while the receive count is above the receive watermark. Writes to 0x14 have no effect.
- R9: The interrupt enable at 0x10 keeps bits 1:0, using the same bit positions as the pending register. `irq` is high when any pending bit is high and its enable bit is set.
- R10: A push and a pop on the same queue in the same cycle both take effect. This covers a bus write with a serializer handshake, and a receive strobe with a receive-data read. The count stays the same and byte order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops the receive queue at 0x04) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_en | output | 1 | Transmit enable setting |
| tx_two_stop | output | 1 | Two stop bits when high |
| rx_strobe | input | 1 | Deserializer byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_en | output | 1 | Receive enable setting |
| baud_div | output | 16 | Baud divisor setting |
| irq | output | 1 | Interrupt request |

## Verification
Each queue can be pushed and popped in the same cycle. For the transmit queue, the bench drives a bus write to 0x00 on the same edge where the serializer takes a byte. For the receive queue, it raises a receive strobe on the same edge as a popping read of 0x04. It then drains each queue and checks the exact byte sequence and the final empty state. This shows that neither operation was lost and that the order was kept. The full-queue drops and the dual watermark comparisons are judged the same way, from what the ports show afterwards.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;
  localparam int BYTE_W = 8;
  localparam int WM_LSB = 16;

  localparam logic [ADDR_W-1:0] OFF_TXD = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_RXD = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_TXC = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_RXC = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_IEN = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_PND = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_DIV = 8'h18;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter  int DEPTH = 8,
  parameter  int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);

  // R10
  push_pop_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> $stable(count));

  // R4
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);
endmodule

// File: rtl/uart_csr_bank.sv
module uart_csr_bank
  import uart_csr_pkg::*;
#(
  parameter  int WM_W  = 3,
  parameter  int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic              tx_en,
  output logic              tx_two_stop,
  output logic [WM_W-1:0]   tx_wm,
  output logic              rx_en,
  output logic [WM_W-1:0]   rx_wm,
  output logic [1:0]        irq_mask,
  output logic [DIV_W-1:0]  divisor
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en       <= 1'b0;
      tx_two_stop <= 1'b0;
      tx_wm       <= '0;
      rx_en       <= 1'b0;
      rx_wm       <= '0;
      irq_mask    <= '0;
      divisor     <= '0;
    end else if (we) begin
      unique case (addr)
        OFF_TXC: begin
          tx_en       <= wdata[0];
          tx_two_stop <= wdata[1];
          tx_wm       <= wdata[WM_LSB +: WM_W];
        end
        OFF_RXC: begin
          rx_en <= wdata[0];
          rx_wm <= wdata[WM_LSB +: WM_W];
        end
        OFF_IEN: irq_mask <= wdata[1:0];
        OFF_DIV: divisor  <= wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  // R6
  tx_wm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFF_TXC) |=> (tx_wm == $past(wdata[WM_LSB +: WM_W])));

  // R7
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == OFF_DIV) |=> $stable(divisor));
endmodule

// File: rtl/uart_csr_fifo.sv
module uart_csr_fifo
  import uart_csr_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int DIV_W = 16,
  localparam int WM_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_en,
  output logic              tx_two_stop,
  input  logic              rx_strobe,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_en,
  output logic [DIV_W-1:0]  baud_div,
  output logic              irq
);
  logic [WM_W-1:0]   tx_wm, rx_wm;
  logic [1:0]        irq_mask, pending;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [BYTE_W-1:0] rx_head;
  logic              tx_push, tx_pop, rx_push, rx_pop;

  uart_csr_bank #(.WM_W(WM_W), .DIV_W(DIV_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .tx_en(tx_en), .tx_two_stop(tx_two_stop), .tx_wm(tx_wm),
    .rx_en(rx_en), .rx_wm(rx_wm), .irq_mask(irq_mask), .divisor(baud_div)
  );

  assign tx_push  = bus_we && (bus_addr == OFF_TXD);
  assign tx_valid = tx_en && !tx_empty;
  assign tx_pop   = tx_valid && tx_ready;

  uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .push_data(bus_wdata[BYTE_W-1:0]),
    .pop(tx_pop), .head(tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  assign rx_push = rx_strobe && rx_en;
  assign rx_pop  = bus_rd && (bus_addr == OFF_RXD);

  uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_byte),
    .pop(rx_pop), .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  always_comb begin
    pending[0] = tx_cnt < CNT_W'(tx_wm);
    pending[1] = rx_cnt > CNT_W'(rx_wm);
  end

  assign irq = |(pending & irq_mask);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_TXD: bus_rdata[BUS_W-1] = tx_full;
      OFF_RXD: begin
        bus_rdata[BUS_W-1] = rx_empty;
        bus_rdata[BYTE_W-1:0] = rx_empty ? '0 : rx_head;
      end
      OFF_TXC: begin
        bus_rdata[0] = tx_en;
        bus_rdata[1] = tx_two_stop;
        bus_rdata[WM_LSB +: WM_W] = tx_wm;
      end
      OFF_RXC: begin
        bus_rdata[0] = rx_en;
        bus_rdata[WM_LSB +: WM_W] = rx_wm;
      end
      OFF_IEN: bus_rdata[1:0] = irq_mask;
      OFF_PND: bus_rdata[1:0] = pending;
      OFF_DIV: bus_rdata[DIV_W-1:0] = baud_div;
      default: ;
    endcase
  end

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && tx_en && !bus_we) |=> (tx_valid && $stable(tx_data)));

  // R9
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_mask != 2'b00));

  // R5
  rx_off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rx_pop) |=> $stable(rx_cnt));
endmodule

// File: tb/sim_uart_csr_fifo.sv
module sim_uart_csr_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tx_valid, tx_ready = 1'b0, tx_en, tx_two_stop;
  logic [7:0]  tx_data, rx_byte = '0;
  logic        rx_strobe = 1'b0, rx_en, irq;
  logic [15:0] baud_div;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_csr_fifo u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_en(tx_en), .tx_two_stop(tx_two_stop), .rx_strobe(rx_strobe),
    .rx_byte(rx_byte), .rx_en(rx_en), .baud_div(baud_div), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0,         8'd6},
    '{1'b0, 8'h08, 32'h0,         32'h0007_0003, 8'd6},
    '{1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0,         8'd6},
    '{1'b0, 8'h0C, 32'h0,         32'h0007_0001, 8'd6},
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,         8'd9},
    '{1'b0, 8'h10, 32'h0,         32'h0000_0003, 8'd9},
    '{1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0,         8'd7},
    '{1'b0, 8'h18, 32'h0,         32'h0000_FFFF, 8'd7},
    '{1'b1, 8'h18, 32'h1234_5678, 32'h0,         8'd7},
    '{1'b0, 8'h18, 32'h0,         32'h0000_5678, 8'd7},
    '{1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0,         8'd8},
    '{1'b0, 8'h14, 32'h0,         32'h0000_0001, 8'd8},
    '{1'b1, 8'h08, 32'h0002_0002, 32'h0,         8'd6},
    '{1'b0, 8'h08, 32'h0,         32'h0002_0002, 8'd6}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 chk(tag, bus_rdata, exp);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_strobe = 1'b1;
    @(negedge clk); rx_strobe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset values of every register
    rd(8'h00, 32'h0, "R1 txdata");
    rd(8'h04, 32'h8000_0000, "R1 rxdata");
    rd(8'h08, 32'h0, "R1 txctrl");
    rd(8'h0C, 32'h0, "R1 rxctrl");
    rd(8'h10, 32'h0, "R1 ie");
    rd(8'h14, 32'h0, "R1 ip");
    rd(8'h18, 32'h0, "R1 div");
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // Vector table: register fields, reserved bits, read-only pending
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].a, VECS[i].d);
      else rd(VECS[i].a, VECS[i].e, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end
    #1;
    chk("R6 tx_two_stop pin", {31'b0, tx_two_stop}, 32'h1);
    chk("R6 tx_en pin", {31'b0, tx_en}, 32'h0);
    chk("R6 rx_en pin", {31'b0, rx_en}, 32'h1);
    chk("R7 baud_div pin", {16'b0, baud_div}, 32'h5678);

    // Transmit: watermark, full flag, drop, order
    do_reset();
    wr(8'h08, 32'h0004_0001);
    wr(8'h10, 32'h1);
    for (int i = 0; i < 3; i++) wr(8'h00, 32'hA0 + i);
    rd(8'h14, 32'h1, "R8 tx count 3 below wm 4");
    #1 chk("R9 irq tx", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'hA3);
    rd(8'h14, 32'h0, "R8 tx count 4 not below wm 4");
    #1 chk("R9 irq off", {31'b0, irq}, 32'h0);
    for (int i = 4; i < 8; i++) wr(8'h00, 32'hA0 + i);
    rd(8'h00, 32'h8000_0000, "R2 full flag");
    wr(8'h00, 32'hFF);
    @(negedge clk); tx_ready = 1'b1;
    #1 chk("R3 valid", {31'b0, tx_valid}, 32'h1);
    chk("R3 byte 0", {24'b0, tx_data}, 32'hA0);
    for (int i = 1; i < 8; i++) begin
      @(negedge clk); #1 chk($sformatf("R3 byte %0d", i), {24'b0, tx_data}, 32'hA0 + i);
    end
    @(negedge clk); #1 chk("R2 dropped write not sent", {31'b0, tx_valid}, 32'h0);
    tx_ready = 1'b0;

    // Transmit disabled holds data back
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h55);
    @(negedge clk); tx_ready = 1'b1;
    #1 chk("R3 disabled no valid", {31'b0, tx_valid}, 32'h0);
    @(negedge clk); tx_ready = 1'b0;
    wr(8'h08, 32'h1);
    #1 chk("R3 enabled valid", {31'b0, tx_valid}, 32'h1);
    chk("R3 enabled data", {24'b0, tx_data}, 32'h55);
    wr(8'h00, 32'h66);
    wr(8'h00, 32'h77);
    #1 chk("R3 hold while not ready", {24'b0, tx_data}, 32'h55);

    // R10: bus push and serializer pop on the same edge
    @(negedge clk);
    tx_ready = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h88; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    #1 chk("R10 tx after same-cycle 1", {24'b0, tx_data}, 32'h66);
    @(negedge clk); #1 chk("R10 tx after same-cycle 2", {24'b0, tx_data}, 32'h77);
    @(negedge clk); #1 chk("R10 tx after same-cycle 3", {24'b0, tx_data}, 32'h88);
    @(negedge clk); #1 chk("R10 tx drained", {31'b0, tx_valid}, 32'h0);
    tx_ready = 1'b0;

    // Receive: watermark, pop, overflow, empty read
    do_reset();
    wr(8'h0C, 32'h0001_0001);
    wr(8'h10, 32'h2);
    rx_put(8'h11);
    rx_put(8'h22);
    rd(8'h14, 32'h2, "R8 rx count 2 above wm 1");
    #1 chk("R9 irq rx", {31'b0, irq}, 32'h1);
    rd(8'h04, 32'h11, "R4 first byte");
    rd(8'h14, 32'h0, "R8 rx count 1 not above wm 1");
    for (int i = 0; i < 7; i++) rx_put(8'h31 + i);
    rx_put(8'hEE);
    rd(8'h04, 32'h22, "R5 byte after refill");
    for (int i = 0; i < 7; i++) rd(8'h04, 32'h31 + i, "R5 order after overflow");
    rd(8'h04, 32'h8000_0000, "R5 overflow byte discarded");
    rd(8'h04, 32'h8000_0000, "R4 empty read does not pop");
    wr(8'h0C, 32'h0);
    rx_put(8'h99);
    rd(8'h04, 32'h8000_0000, "R5 disabled strobe ignored");

    // R10: receive strobe and popping read on the same edge
    wr(8'h0C, 32'h1);
    rx_put(8'h41);
    @(negedge clk);
    bus_addr = 8'h04; bus_rd = 1'b1; rx_byte = 8'h42; rx_strobe = 1'b1;
    #1 chk("R10 rx read during strobe", bus_rdata, 32'h41);
    @(negedge clk); bus_rd = 1'b0; rx_strobe = 1'b0;
    rd(8'h04, 32'h42, "R10 rx new byte kept");
    rd(8'h04, 32'h8000_0000, "R10 rx empty after");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule